// File: doc/BRIEF.md
# Dual Packet Buffer Mode Controller

This block holds an 8-bit MAC control word that a host writes. The word decides how two host address windows reach a pair of packet buffers. There are three transfer modes. In the split mode, one buffer serves transmit and the other serves receive. In the transmit-streaming mode, both buffers are used for transmit behind one window. In the receive-streaming mode, both buffers are used for receive behind the other window. In the streaming modes, the datapath sends a one-cycle buffer-done pulse when it has finished with a buffer, and the host side then moves to the other buffer.

The block also keeps three radio control flags: receive enable, transmit start and crypt enable. A mode write changes these flags as a side effect. While a frame is being sent or received, the block refuses changes to the fields that would corrupt that frame. It also rejects mode writes that are not legal.

For each host access, the block translates the address into a buffer number, a local offset and a valid flag. It gates the write strobe with the valid flag. It also outputs the address width and CRC width in octets, decoded from their code fields.

Top module: `pbm_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0C (mode 00, address code 001, CRC bit 1, frame bit 0, override bit 0). `cfg_err` is low and all three flags are low.
- R2: `addr_octets` equals the address code (bits 5:3) plus one. `crc_octets` is 2 when bit 2 is set and 0 when it is clear.
- R3: In mode 00, addresses 0x200..0x27F map to buffer 0 with offset address−0x200, and 0x300..0x383 map to buffer 1 with offset address−0x300.
- R4: In mode 10 (transmit streaming), 0x200..0x27F map to the current buffer selector, and 0x300..0x383 are invalid.
- R5: In mode 01 (receive streaming), 0x300..0x383 map to the current buffer selector, and 0x200..0x27F are invalid.
- R6: The selector flips one cycle after a `buf_done` pulse in a streaming mode. It ignores the pulse in mode 00. It returns to buffer 0 when an accepted write changes the mode.
- R7: An accepted write of mode 10 leaves receive enable low on the next cycle.
- R8: An accepted write of mode 01 leaves receive enable high and both transmit start and crypt enable low on the next cycle.
- R9: A write of mode 11 is rejected. The mode field and the frame bit (bit 1) keep their values, and `cfg_err` is high for exactly the next cycle.
- R10: A write that asks for a streaming mode while the resulting frame bit is 0 is rejected in the same way as R9. As a result, frame bit 0 always comes with mode 00.
- R11: While receive enable or transmit start is high, writes leave the address code and the frame bit unchanged. The CRC bit and the override bit still update.
- R12: An address outside every window of the current mode gives `acc_valid`=0, `acc_buf`=0 and `acc_off`=0. `acc_we` is high only when `host_we` and `acc_valid` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Current control word |
| cfg_err | output | 1 | One-cycle pulse after a rejected mode write |
| flg_we | input | 1 | Flag write strobe |
| flg_wdata | input | 3 | Flag write data: bit 0 receive enable, bit 1 transmit start, bit 2 crypt enable |
| rx_en | output | 1 | Receive enable flag |
| tx_start | output | 1 | Transmit start flag |
| crypt_en | output | 1 | Encrypt/decrypt enable flag |
| buf_done | input | 1 | Datapath finished with the current streaming buffer |
| host_addr | input | 10 | Host access address |
| host_we | input | 1 | Host access is a write |
| acc_valid | output | 1 | Address falls in a window of the current mode |
| acc_buf | output | 1 | Selected buffer: 0 or 1 |
| acc_off | output | 8 | Offset inside the selected buffer |
| acc_we | output | 1 | Gated buffer write strobe |
| addr_octets | output | 4 | Decoded address width in octets |
| crc_octets | output | 2 | Decoded CRC width in octets |
| sec_ovr | output | 1 | Security flag override bit |

## Verification
The address decode is combinational. Its outputs are checked in the same cycle that the address is applied. Control-word writes, flag writes and `buf_done` pulses each pass through one register, so the control word, flags, error pulse, size outputs and selector are checked exactly one cycle after the strobe. The error pulse is checked once more one cycle later to confirm that it has dropped. Each stimulus task registers the expected values together with the cycle in which they are due. The monitor compares them only at the falling edge of that cycle.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [1:0] {
        XM_SPLIT   = 2'b00,
        XM_RX_STRM = 2'b01,
        XM_TX_STRM = 2'b10,
        XM_RSVD    = 2'b11
    } xmode_e;

    typedef struct packed {
        xmode_e     mode;
        logic [2:0] asz_code;
        logic       crc_on;
        logic       frm_own;
        logic       sec_ovr;
    } ctl_word_t;

    typedef struct packed {
        logic crypt;
        logic tx_start;
        logic rx_en;
    } flags_t;

    localparam ctl_word_t CTL_RST = '{
        mode:     XM_SPLIT,
        asz_code: 3'b001,
        crc_on:   1'b1,
        frm_own:  1'b0,
        sec_ovr:  1'b0
    };

    localparam int NWIN = 2;

    function automatic logic is_stream(xmode_e m);
        return (m == XM_RX_STRM) || (m == XM_TX_STRM);
    endfunction

    function automatic logic [3:0] asz_octets(logic [2:0] code);
        return {1'b0, code} + 4'd1;
    endfunction

    function automatic logic [1:0] crc_width(logic on);
        return on ? 2'd2 : 2'd0;
    endfunction

endpackage

// File: rtl/pbm_cfg_reg.sv
module pbm_cfg_reg
    import pbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       flg_we,
    input  logic [2:0] flg_wdata,
    output ctl_word_t  ctl_q,
    output flags_t     flg_q,
    output logic       err_q,
    output logic       mode_load
);

    ctl_word_t wr_w;
    ctl_word_t ctl_d;
    flags_t    flg_d;
    logic      busy;
    logic      mode_bad;

    assign wr_w = ctl_word_t'(cfg_wdata);
    assign busy = flg_q.rx_en | flg_q.tx_start;

    always_comb begin
        ctl_d    = ctl_q;
        flg_d    = flg_q;
        mode_bad = 1'b0;
        if (flg_we) begin
            flg_d = flags_t'(flg_wdata);
        end
        if (cfg_we) begin
            ctl_d.crc_on  = wr_w.crc_on;
            ctl_d.sec_ovr = wr_w.sec_ovr;
            if (!busy) begin
                ctl_d.asz_code = wr_w.asz_code;
                ctl_d.frm_own  = wr_w.frm_own;
            end
            // mode and frame bit are accepted or refused together
            mode_bad = (wr_w.mode == XM_RSVD) ||
                       (is_stream(wr_w.mode) && !ctl_d.frm_own);
            if (mode_bad) begin
                ctl_d.frm_own = ctl_q.frm_own;
            end else begin
                ctl_d.mode = wr_w.mode;
                case (wr_w.mode)
                    XM_TX_STRM: flg_d.rx_en = 1'b0;
                    XM_RX_STRM: begin
                        flg_d.rx_en    = 1'b1;
                        flg_d.tx_start = 1'b0;
                        flg_d.crypt    = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mode_load = cfg_we && !mode_bad && (wr_w.mode != ctl_q.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RST;
            flg_q <= '0;
            err_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            flg_q <= flg_d;
            err_q <= cfg_we && mode_bad;
        end
    end

endmodule

// File: rtl/pbm_buf_sel.sv
module pbm_buf_sel
    import pbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xmode_e mode,
    input  logic   mode_load,
    input  logic   buf_done,
    output logic   sel_q
);

    logic sel_d;

    always_comb begin
        sel_d = sel_q;
        if (mode_load) begin
            sel_d = 1'b0;
        end else if (is_stream(mode) && buf_done) begin
            sel_d = ~sel_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_d;
    end

endmodule

// File: rtl/pbm_addr_map.sv
module pbm_addr_map
    import pbm_pkg::*;
#(
    parameter int HADDR_W = 10,
    parameter int OFF_W   = 8,
    parameter logic [HADDR_W-1:0] TXW_BASE = 10'h200,
    parameter int TXW_LEN = 128,
    parameter logic [HADDR_W-1:0] RXW_BASE = 10'h300,
    parameter int RXW_LEN = 132
) (
    input  xmode_e             mode,
    input  logic               sel,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_we,
    output logic               acc_valid,
    output logic               acc_buf,
    output logic [OFF_W-1:0]   acc_off,
    output logic               acc_we
);

    localparam logic [HADDR_W:0] W_LO [NWIN] = '{
        {1'b0, TXW_BASE}, {1'b0, RXW_BASE}
    };
    localparam logic [HADDR_W:0] W_HI [NWIN] = '{
        {1'b0, TXW_BASE} + (HADDR_W+1)'(TXW_LEN),
        {1'b0, RXW_BASE} + (HADDR_W+1)'(RXW_LEN)
    };

    logic [NWIN-1:0] hit;
    logic [OFF_W-1:0] woff [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [HADDR_W:0] a_ext;
        logic [HADDR_W:0] diff;
        assign a_ext   = {1'b0, host_addr};
        assign diff    = a_ext - W_LO[w];
        assign hit[w]  = (a_ext >= W_LO[w]) && (a_ext < W_HI[w]);
        assign woff[w] = diff[OFF_W-1:0];
    end

    always_comb begin
        acc_valid = 1'b0;
        acc_buf   = 1'b0;
        acc_off   = '0;
        case (mode)
            XM_SPLIT: begin
                if (hit[0]) begin
                    acc_valid = 1'b1;
                    acc_off   = woff[0];
                end else if (hit[1]) begin
                    acc_valid = 1'b1;
                    acc_buf   = 1'b1;
                    acc_off   = woff[1];
                end
            end
            XM_TX_STRM: begin
                if (hit[0]) begin
                    acc_valid = 1'b1;
                    acc_buf   = sel;
                    acc_off   = woff[0];
                end
            end
            XM_RX_STRM: begin
                if (hit[1]) begin
                    acc_valid = 1'b1;
                    acc_buf   = sel;
                    acc_off   = woff[1];
                end
            end
            default: ;
        endcase
    end

    assign acc_we = host_we && acc_valid;

endmodule

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
    import pbm_pkg::*;
#(
    parameter int HADDR_W = 10,
    parameter int OFF_W   = 8,
    parameter logic [HADDR_W-1:0] TXW_BASE = 10'h200,
    parameter int TXW_LEN = 128,
    parameter logic [HADDR_W-1:0] RXW_BASE = 10'h300,
    parameter int RXW_LEN = 132
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               cfg_err,
    input  logic               flg_we,
    input  logic [2:0]         flg_wdata,
    output logic               rx_en,
    output logic               tx_start,
    output logic               crypt_en,
    input  logic               buf_done,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_we,
    output logic               acc_valid,
    output logic               acc_buf,
    output logic [OFF_W-1:0]   acc_off,
    output logic               acc_we,
    output logic [3:0]         addr_octets,
    output logic [1:0]         crc_octets,
    output logic               sec_ovr
);

    ctl_word_t ctl;
    flags_t    flg;
    logic      mode_load;
    logic      buf_sel;

    pbm_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .flg_we    (flg_we),
        .flg_wdata (flg_wdata),
        .ctl_q     (ctl),
        .flg_q     (flg),
        .err_q     (cfg_err),
        .mode_load (mode_load)
    );

    pbm_buf_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .mode      (ctl.mode),
        .mode_load (mode_load),
        .buf_done  (buf_done),
        .sel_q     (buf_sel)
    );

    pbm_addr_map #(
        .HADDR_W  (HADDR_W),
        .OFF_W    (OFF_W),
        .TXW_BASE (TXW_BASE),
        .TXW_LEN  (TXW_LEN),
        .RXW_BASE (RXW_BASE),
        .RXW_LEN  (RXW_LEN)
    ) u_map (
        .mode      (ctl.mode),
        .sel       (buf_sel),
        .host_addr (host_addr),
        .host_we   (host_we),
        .acc_valid (acc_valid),
        .acc_buf   (acc_buf),
        .acc_off   (acc_off),
        .acc_we    (acc_we)
    );

    assign cfg_rdata   = ctl;
    assign rx_en       = flg.rx_en;
    assign tx_start    = flg.tx_start;
    assign crypt_en    = flg.crypt;
    assign addr_octets = asz_octets(ctl.asz_code);
    assign crc_octets  = crc_width(ctl.crc_on);
    assign sec_ovr     = ctl.sec_ovr;

endmodule

// File: rtl/pbm_ctrl_chk.sv
module pbm_ctrl_chk #(
    parameter int HADDR_W = 10,
    parameter logic [HADDR_W-1:0] RXW_BASE = 10'h300
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [7:0]         cfg_wdata,
    input logic [7:0]         cfg_rdata,
    input logic               cfg_err,
    input logic               rx_en,
    input logic               tx_start,
    input logic               crypt_en,
    input logic               buf_done,
    input logic [HADDR_W-1:0] host_addr,
    input logic               acc_valid,
    input logic               acc_buf,
    input logic               acc_we
);

    p_rsvd_reject_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wdata[7:6] == 2'b11
        |=> cfg_err && cfg_rdata[7:6] == $past(cfg_rdata[7:6]));

    p_std_frame_split_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[1] |-> cfg_rdata[7:6] == 2'b00);

    p_busy_guard_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_we && (rx_en || tx_start)
        |=> cfg_rdata[5:3] == $past(cfg_rdata[5:3]) && cfg_rdata[1] == $past(cfg_rdata[1]));

    p_txs_rxoff_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wdata[7:6] == 2'b10 |=> cfg_err || !rx_en);

    p_rxs_flags_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wdata[7:6] == 2'b01
        |=> cfg_err || (rx_en && !tx_start && !crypt_en));

    p_we_gated_r12: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> acc_valid);

    p_txs_window_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:6] == 2'b10 && acc_valid |-> host_addr < RXW_BASE);

    p_rxs_window_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:6] == 2'b01 && acc_valid |-> host_addr >= RXW_BASE);

    p_sel_flip_r6: assert property (@(posedge clk) disable iff (rst)
        buf_done && !cfg_we && acc_valid && cfg_rdata[7:6] != 2'b00
        |=> ($stable(host_addr) |-> acc_buf != $past(acc_buf)));

endmodule

bind pbm_ctrl pbm_ctrl_chk #(
    .HADDR_W  (HADDR_W),
    .RXW_BASE (RXW_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_err   (cfg_err),
    .rx_en     (rx_en),
    .tx_start  (tx_start),
    .crypt_en  (crypt_en),
    .buf_done  (buf_done),
    .host_addr (host_addr),
    .acc_valid (acc_valid),
    .acc_buf   (acc_buf),
    .acc_we    (acc_we)
);

// File: tb/pbm_ctrl_tb.sv
module pbm_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    localparam int S_CFG   = 0;
    localparam int S_ERR   = 1;
    localparam int S_FLG   = 2;
    localparam int S_ACC   = 3;
    localparam int S_WE    = 4;
    localparam int S_SIZES = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cfg_err;
    logic       flg_we = 1'b0;
    logic [2:0] flg_wdata = '0;
    logic       rx_en, tx_start, crypt_en;
    logic       buf_done = 1'b0;
    logic [9:0] host_addr = '0;
    logic       host_we = 1'b0;
    logic       acc_valid, acc_buf, acc_we;
    logic [7:0] acc_off;
    logic [3:0] addr_octets;
    logic [1:0] crc_octets;
    logic       sec_ovr;

    pbm_ctrl u_dut (
        .clk (clk), .rst (rst),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .cfg_err (cfg_err),
        .flg_we (flg_we), .flg_wdata (flg_wdata),
        .rx_en (rx_en), .tx_start (tx_start), .crypt_en (crypt_en),
        .buf_done (buf_done), .host_addr (host_addr), .host_we (host_we),
        .acc_valid (acc_valid), .acc_buf (acc_buf), .acc_off (acc_off), .acc_we (acc_we),
        .addr_octets (addr_octets), .crc_octets (crc_octets), .sec_ovr (sec_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        string       req;
        int          sig;
        logic [15:0] val;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc++;

    function automatic logic [15:0] observe(int sig);
        case (sig)
            S_CFG:   return {8'b0, cfg_rdata};
            S_ERR:   return {15'b0, cfg_err};
            S_FLG:   return {13'b0, crypt_en, tx_start, rx_en};
            S_ACC:   return {6'b0, acc_valid, acc_buf, acc_off};
            S_WE:    return {15'b0, acc_we};
            default: return {10'b0, addr_octets, crc_octets};
        endcase
    endfunction

    // monitor: compares every item due in this cycle
    always @(negedge clk) begin
        exp_t        e;
        logic [15:0] got;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e   = q.pop_front();
            got = observe(e.sig);
            n_cmp++;
            if (got !== e.val) begin
                n_bad++;
                $display("FAIL %s signal %0d: actual %h expected %h", e.req, e.sig, got, e.val);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_now(string req, int sig, logic [15:0] val);
        exp_t e;
        e.due = cyc;
        e.req = req;
        e.sig = sig;
        e.val = val;
        q.push_back(e);
    endtask

    task automatic wr_cfg(logic [7:0] d);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic wr_flg(logic [2:0] f);
        flg_we    = 1'b1;
        flg_wdata = f;
        tick();
        flg_we    = 1'b0;
    endtask

    task automatic pulse_done();
        buf_done = 1'b1;
        tick();
        buf_done = 1'b0;
    endtask

    // acc code: {valid, buf, off[7:0]}
    task automatic probe(string req, logic [9:0] a, logic we, logic [9:0] acc);
        host_addr = a;
        host_we   = we;
        expect_now(req, S_ACC, {6'b0, acc});
        expect_now(req, S_WE, {15'b0, we & acc[9]});
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state, R2 decoded reset sizes
        expect_now("R1", S_CFG, 16'h000C);
        expect_now("R1", S_ERR, 16'h0000);
        expect_now("R1", S_FLG, 16'h0000);
        expect_now("R2", S_SIZES, 16'h000A);
        tick();

        // R3 split map
        probe("R3", 10'h205, 1'b1, 10'h205);
        probe("R3", 10'h383, 1'b0, 10'h383);
        // R12 gaps and edges
        probe("R12", 10'h280, 1'b1, 10'h000);
        probe("R12", 10'h384, 1'b1, 10'h000);
        probe("R12", 10'h1FF, 1'b1, 10'h000);
        // R6 split ignores buf_done
        pulse_done();
        probe("R6", 10'h210, 1'b0, 10'h210);

        // R2 new sizes, frame bit 1
        wr_cfg(8'h1A);
        expect_now("R2", S_CFG, 16'h001A);
        expect_now("R2", S_SIZES, 16'h0010);
        tick();

        // R7 transmit streaming clears receive enable
        wr_flg(3'b001);
        expect_now("R7", S_FLG, 16'h0001);
        wr_cfg(8'h9A);
        expect_now("R7", S_CFG, 16'h009A);
        expect_now("R7", S_FLG, 16'h0000);
        expect_now("R7", S_ERR, 16'h0000);
        tick();

        // R4 windows in transmit streaming
        probe("R4", 10'h200, 1'b1, 10'h200);
        probe("R4", 10'h300, 1'b1, 10'h000);
        // R6 toggling
        pulse_done();
        probe("R6", 10'h27F, 1'b0, 10'h37F);
        pulse_done();
        probe("R6", 10'h27F, 1'b0, 10'h27F);

        // R9 reserved mode rejected
        wr_cfg(8'hDA);
        expect_now("R9", S_CFG, 16'h009A);
        expect_now("R9", S_ERR, 16'h0001);
        tick();
        expect_now("R9", S_ERR, 16'h0000);
        tick();

        // R11 guard while transmit start set
        wr_flg(3'b110);
        expect_now("R11", S_FLG, 16'h0006);
        wr_cfg(8'h8E);
        expect_now("R11", S_CFG, 16'h009E);
        wr_cfg(8'h9C);
        expect_now("R11", S_CFG, 16'h009E);
        expect_now("R11", S_ERR, 16'h0000);

        // R8 receive streaming and R6 selector reset
        pulse_done();
        wr_cfg(8'h5E);
        expect_now("R8", S_CFG, 16'h005E);
        expect_now("R8", S_FLG, 16'h0001);
        expect_now("R8", S_ERR, 16'h0000);
        tick();
        probe("R6", 10'h300, 1'b1, 10'h200);
        probe("R5", 10'h200, 1'b1, 10'h000);
        pulse_done();
        probe("R5", 10'h383, 1'b1, 10'h383);

        // R10 streaming refused with standard frames
        wr_flg(3'b000);
        wr_cfg(8'h1C);
        expect_now("R10", S_CFG, 16'h001C);
        wr_cfg(8'h9C);
        expect_now("R10", S_CFG, 16'h001C);
        expect_now("R10", S_ERR, 16'h0001);
        wr_cfg(8'h4C);
        expect_now("R10", S_CFG, 16'h000C);
        expect_now("R10", S_ERR, 16'h0001);
        expect_now("R2", S_SIZES, 16'h000A);
        tick();
        probe("R3", 10'h300, 1'b0, 10'h300);

        repeat (3) tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule